// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out a block load or block store for a small in-order processor core. It takes a sixteen-entry register mask, the base register index and its value, and five mode bits. It then moves one word per clock between the register file and memory. Registers are always visited in ascending index order, with index 15 last, and they map to ascending word addresses. This holds whether the mode steps the base upward or downward.

The sequencer computes the lowest address touched and the updated base. It writes the updated base back when that is requested. If a memory access reports an error, it recovers as follows. A failed load stops further register updates, undoes the load that went just before it, and puts the base back. A failed store lets the remaining writes run and reports the fault at the end. A start address beyond the legal address range turns every store into a harmless read and ends in an exception. A separate output asks the register file to use the user-mode bank.

The register file read port and the memory port both answer in the same cycle as the request. A `start` pulse while idle launches an operation. `done` pulses once when it has finished, with `exc` beside it if the operation faulted.

Top module: `mrt_sequencer`

## Requirements
- R1: During the transfer phase, exactly one memory access is issued per cycle, one per selected register. Registers are visited in ascending index order with index 15 last, and each access address is the previous one plus 4.
- R2: Let n be the number of selected registers. `up_mode`=1 steps upward: the updated base is base+4n and the lowest address is base. `up_mode`=0 steps downward: the updated base is base−4n and the lowest address is base−4n. The first access is the lowest address plus 4 when `pre_mode` equals `up_mode`, and the lowest address otherwise.
- R3: Write-back happens one cycle after `start` and places the updated base into register `base_sel`. It requires all of the following: `wb_req`=1, `base_sel`≠15, and the operation is not a load whose mask contains `base_sel`.
- R4: On a store, the first access carries the original base value if the first selected register is `base_sel` (≠15). Every other store carries the register file contents as they stand after any write-back.
- R5: On the first failed load, that load is not written, and the register written by the previous load gets its earlier value back. No further loaded data is written. Reads continue at the remaining addresses. At completion the base register receives the updated base if write-back applied, and the original base otherwise.
- R6: A failed store does not stop the sequence: every remaining write is still issued, and `exc` is raised with `done`.
- R7: If the first access address has any bit at position 26 or above set, all accesses are reads (`mem_we`=0) and `exc` is raised with `done`.
- R8: When `user_sel`=1, register-file accesses during the transfer phase use the user bank (`rf_user_bank`=1). The exception is a load that includes index 15, which uses the current bank.
- R9: A load of index 15 writes register 15 from the loaded word in the `done` cycle, and only if there was no exception. If `user_sel`=1, `status_we` also pulses in that cycle.
- R10: An empty mask gives `done` one cycle after `start`, with no memory access, no register write and no exception.
- R11: For a non-empty mask, `done` is a single-cycle pulse exactly n+2 cycles after `start`. `exc` is only ever high with `done`.
- R12: After reset, `done`, `exc`, `mem_req`, `rf_we` and `status_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation (sampled while idle) |
| reg_list | input | 16 | Register selection mask |
| base_sel | input | 4 | Index of the base register |
| base_val | input | 32 | Current base value |
| up_mode | input | 1 | 1 = step upward, 0 = step downward |
| pre_mode | input | 1 | 1 = adjust before the access, 0 = after |
| wb_req | input | 1 | Request base write-back |
| user_sel | input | 1 | User bank / status load selector |
| is_load | input | 1 | 1 = load from memory, 0 = store |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rf_user_bank | output | 1 | Select user bank for this access |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory write (0 = read) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| mem_err | input | 1 | Error response for the current access |
| status_we | output | 1 | Load status bits from `rf_wdata` |
| done | output | 1 | Operation complete pulse |
| exc | output | 1 | Operation faulted (with `done`) |

## Verification
The sweep covers all four stepping modes, loads and stores, with and without write-back. It uses masks that do and do not contain the base register, and it places the base first, in the middle and at index 15. A design that stepped addresses downward, or mis-applied the +4 for the two matching mode combinations, would produce a wrong address list. A design that let a load overwrite its own base would leave the wrong final base in the register model.

Errors are injected at every position of an eight-register mask. A design that failed to undo the previous load would leave a corrupted register. A design that stopped issuing accesses after a fault would cut the access list short. A store error must not truncate the writes.

Start addresses just below and exactly at the range limit catch an off-by-one in the range test. With `user_sel` set, a design that wrote the wrong bank or skipped the status pulse shows up in the two-bank register model.

// File: rtl/mrt_pkg.sv
// Shared types for the multiple-register transfer sequencer.
// Assumes a single clock domain; nothing here holds state.
package mrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/mrt_popcount.sv
// Counts the set bits of a register mask.
// Assumes CW is wide enough to hold W.
module mrt_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // Sum every mask bit into the count.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/mrt_lowest.sv
// Finds the lowest set bit of a mask: one-hot form, binary index, and
// whether it is the only bit left. Assumes IW = clog2(W).
module mrt_lowest #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          last
);
    logic [W:0] below;  // below[i]: some bit under position i is set

    assign below[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_chain
            assign onehot[g]    = vec[g] & ~below[g];
            assign below[g + 1] = below[g] | vec[g];
        end
    endgenerate

    // Encode the one-hot position as an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = IW'(i);
        end
    end

    assign last = ((vec & ~onehot) == '0);
endmodule

// File: rtl/mrt_addr_gen.sv
// Derives the first access address, the updated base and the range fault
// from the base, the register count and the two stepping bits.
// Assumes words are 4 bytes and addresses wrap modulo 2^DW.
module mrt_addr_gen #(
    parameter int DW         = 32,
    parameter int CW         = 5,
    parameter int LIMIT_LOG2 = 26
) (
    input  logic [DW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          up,
    input  logic          pre,
    output logic [DW-1:0] first_addr,
    output logic [DW-1:0] new_base,
    output logic          out_of_range
);
    logic [DW-1:0] span;
    logic [DW-1:0] low_addr;

    // Block size in bytes, the two end points and the first access.
    always_comb begin
        span         = DW'(count) << 2;
        new_base     = up ? base + span : base - span;
        low_addr     = up ? base : base - span;
        first_addr   = (up == pre) ? low_addr + DW'(4) : low_addr;
        out_of_range = |first_addr[DW-1:LIMIT_LOG2];
    end
endmodule

// File: rtl/mrt_sequencer.sv
// Multi-cycle block load/store sequencer. One word per cycle, ascending
// register order and ascending addresses. Handles base write-back, load
// abort recovery, store fault deferral and the address range fault.
// Assumes the register file read and the memory response are combinational
// (same cycle) and that one register file write port is available.
module mrt_sequencer #(
    parameter int DW         = 32,
    parameter int NREG       = 16,
    parameter int LIMIT_LOG2 = 26,
    localparam int IW = $clog2(NREG),
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] reg_list,
    input  logic [IW-1:0]   base_sel,
    input  logic [DW-1:0]   base_val,
    input  logic            up_mode,
    input  logic            pre_mode,
    input  logic            wb_req,
    input  logic            user_sel,
    input  logic            is_load,
    output logic [IW-1:0]   rf_raddr,
    input  logic [DW-1:0]   rf_rdata,
    output logic            rf_we,
    output logic [IW-1:0]   rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            rf_user_bank,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_err,
    output logic            status_we,
    output logic            done,
    output logic            exc
);
    import mrt_pkg::*;

    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    seq_state_t      state_q;
    logic [NREG-1:0] list_q, rem_q;
    logic [IW-1:0]   bsel_q, prev_idx_q;
    logic [DW-1:0]   base_q, addr_q, prev_val_q, pc_hold_q;
    logic            up_q, pre_q, wb_q, s_q, ld_q;
    logic            first_q, ld_abort_q, st_fault_q, range_q, prev_valid_q;

    logic [CW-1:0]   n_regs;
    logic [DW-1:0]   first_addr, new_base;
    logic            out_of_range;
    logic [NREG-1:0] cur_onehot;
    logic [IW-1:0]   cur_idx;
    logic            cur_last;
    logic            wb_en, adopt_user, fault_any, base_is_pc;

    mrt_popcount #(.W(NREG), .CW(CW)) u_count (
        .vec(list_q), .count(n_regs)
    );

    mrt_addr_gen #(.DW(DW), .CW(CW), .LIMIT_LOG2(LIMIT_LOG2)) u_addr (
        .base(base_q), .count(n_regs), .up(up_q), .pre(pre_q),
        .first_addr(first_addr), .new_base(new_base),
        .out_of_range(out_of_range)
    );

    mrt_lowest #(.W(NREG), .IW(IW)) u_pick (
        .vec(rem_q), .onehot(cur_onehot), .idx(cur_idx), .last(cur_last)
    );

    // Operation-wide qualifiers derived from the latched request.
    always_comb begin
        base_is_pc = (bsel_q == PC_IDX);
        wb_en      = wb_q && !base_is_pc && !(ld_q && list_q[bsel_q]);
        adopt_user = s_q && !(ld_q && list_q[PC_IDX]);
        fault_any  = range_q || ld_abort_q || st_fault_q;
    end

    // Sequence control and per-operation bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            list_q       <= '0;
            rem_q        <= '0;
            bsel_q       <= '0;
            base_q       <= '0;
            addr_q       <= '0;
            up_q         <= 1'b0;
            pre_q        <= 1'b0;
            wb_q         <= 1'b0;
            s_q          <= 1'b0;
            ld_q         <= 1'b0;
            first_q      <= 1'b0;
            ld_abort_q   <= 1'b0;
            st_fault_q   <= 1'b0;
            range_q      <= 1'b0;
            prev_valid_q <= 1'b0;
            prev_idx_q   <= '0;
            prev_val_q   <= '0;
            pc_hold_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        list_q     <= reg_list;
                        bsel_q     <= base_sel;
                        base_q     <= base_val;
                        up_q       <= up_mode;
                        pre_q      <= pre_mode;
                        wb_q       <= wb_req;
                        s_q        <= user_sel;
                        ld_q       <= is_load;
                        ld_abort_q <= 1'b0;
                        st_fault_q <= 1'b0;
                        range_q    <= 1'b0;
                        state_q    <= (reg_list == '0) ? ST_DONE : ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    rem_q        <= list_q;
                    addr_q       <= first_addr;
                    range_q      <= out_of_range;
                    first_q      <= 1'b1;
                    prev_valid_q <= 1'b0;
                    state_q      <= ST_XFER;
                end
                ST_XFER: begin
                    addr_q  <= addr_q + DW'(4);
                    rem_q   <= rem_q & ~cur_onehot;
                    first_q <= 1'b0;
                    if (ld_q && !ld_abort_q) begin
                        if (mem_err) begin
                            ld_abort_q <= 1'b1;
                        end else begin
                            prev_valid_q <= 1'b1;
                            prev_idx_q   <= cur_idx;
                            prev_val_q   <= rf_rdata;
                            if (cur_idx == PC_IDX) pc_hold_q <= mem_rdata;
                        end
                    end
                    if (!ld_q && mem_err) st_fault_q <= 1'b1;
                    if (cur_last) state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory and register-file read side of the current transfer.
    always_comb begin
        rf_raddr     = cur_idx;
        mem_req      = (state_q == ST_XFER);
        mem_we       = mem_req && !ld_q && !range_q;
        mem_addr     = addr_q;
        mem_wdata    = (first_q && cur_idx == bsel_q && !base_is_pc) ? base_q : rf_rdata;
        rf_user_bank = mem_req && adopt_user;
    end

    // Single register-file write port: write-back, loads, undo, final fix-up.
    always_comb begin
        rf_we     = 1'b0;
        rf_waddr  = bsel_q;
        rf_wdata  = new_base;
        status_we = 1'b0;
        unique case (state_q)
            ST_SETUP: rf_we = wb_en;
            ST_XFER: begin
                if (ld_q && !ld_abort_q) begin
                    if (mem_err) begin
                        rf_we    = prev_valid_q;
                        rf_waddr = prev_idx_q;
                        rf_wdata = prev_val_q;
                    end else if (cur_idx != PC_IDX) begin
                        rf_we    = 1'b1;
                        rf_waddr = cur_idx;
                        rf_wdata = mem_rdata;
                    end
                end
            end
            ST_DONE: begin
                if (ld_q && ld_abort_q && !base_is_pc) begin
                    rf_we    = 1'b1;
                    rf_wdata = wb_en ? new_base : base_q;
                end else if (ld_q && list_q[PC_IDX] && !fault_any) begin
                    rf_we     = 1'b1;
                    rf_waddr  = PC_IDX;
                    rf_wdata  = pc_hold_q;
                    status_we = s_q;
                end
            end
            default: ;
        endcase
    end

    assign done = (state_q == ST_DONE);
    assign exc  = done && fault_any;

    // R1: consecutive accesses step by one word.
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + DW'(4));

    // R11: completion is a one-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the fault flag only accompanies completion.
    p_exc_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> done);

    // R5: after a failed load, later transfer cycles write nothing.
    p_quiet_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req && mem_err && !mem_we && ld_q) |-> !rf_we);

    // R9: a status load always rides on a write of register 15.
    p_status_with_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> rf_we && rf_waddr == PC_IDX && done);

    // R8: the user bank is only requested alongside a memory access.
    p_bank_in_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_user_bank |-> mem_req);
endmodule

// File: tb/mrt_sequencer_test.sv
module mrt_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] reg_list;
    logic [3:0]  base_sel;
    logic [31:0] base_val;
    logic        up_mode, pre_mode, wb_req, user_sel, is_load;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, rf_user_bank;
    logic        mem_req, mem_we, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        status_we, done, exc;

    logic [31:0] nb [16];
    logic [31:0] ub [16];
    logic [31:0] enb [16];
    logic [31:0] eub [16];
    logic [31:0] acc_addr [32];
    logic        acc_we   [32];
    logic [31:0] acc_wd   [32];
    logic [31:0] eacc_addr [16];
    logic        eacc_we   [16];
    logic [31:0] eacc_wd   [16];
    int          acc_cnt;
    logic        stat_seen;
    logic        err_on;
    logic [31:0] err_addr;
    int          vectors = 0;
    int          fails   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_3C3C;
    endfunction

    function automatic logic [31:0] init_n(input int i);
        return 32'h1100_0000 + 32'(i) * 32'h0001_0101;
    endfunction

    function automatic logic [31:0] init_u(input int i);
        return 32'h2200_0000 + 32'(i) * 32'h0003_0007;
    endfunction

    assign rf_rdata  = rf_user_bank ? ub[rf_raddr] : nb[rf_raddr];
    assign mem_rdata = mdata(mem_addr);
    assign mem_err   = mem_req && err_on && (mem_addr == err_addr);

    mrt_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
        .base_sel(base_sel), .base_val(base_val), .up_mode(up_mode),
        .pre_mode(pre_mode), .wb_req(wb_req), .user_sel(user_sel),
        .is_load(is_load), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_user_bank(rf_user_bank), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .status_we(status_we), .done(done), .exc(exc)
    );

    // Register file model, access log and status capture.
    always @(posedge clk) begin
        if (rf_we) begin
            if (rf_user_bank) ub[rf_waddr] <= rf_wdata;
            else              nb[rf_waddr] <= rf_wdata;
        end
        if (mem_req && acc_cnt < 32) begin
            acc_addr[acc_cnt] <= mem_addr;
            acc_we[acc_cnt]   <= mem_we;
            acc_wd[acc_cnt]   <= mem_wdata;
        end
        if (mem_req) acc_cnt <= acc_cnt + 1;
        if (status_we) stat_seen <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [15:0] lst, input logic [3:0] bs,
                            input logic [31:0] bv, input logic u, input logic p,
                            input logic w, input logic s, input logic l,
                            input logic eon, input logic [31:0] eaddr);
        int n, k, cyc;
        logic [31:0] span, fin, lo, st, a, cur, pold, pcv;
        logic aerr, wbe, adopt, ab, serr, pv, eexc, estat, ok, got_exc;
        logic [3:0] pidx;
        // Expected model from the requirements.
        for (int i = 0; i < 16; i++) begin
            enb[i] = init_n(i);
            eub[i] = init_u(i);
        end
        if (bs != 4'd15) enb[bs] = bv;
        n     = $countones(lst);
        span  = 32'(n) * 32'd4;
        fin   = u ? bv + span : bv - span;
        lo    = u ? bv : bv - span;
        st    = (u == p) ? lo + 32'd4 : lo;
        aerr  = (n != 0) && (st >= 32'h0400_0000);
        wbe   = w && (bs != 4'd15) && !(l && lst[bs]);
        adopt = s && !(l && lst[15]);
        if (n != 0 && wbe) enb[bs] = fin;   // R3
        k = 0; ab = 0; serr = 0; pv = 0; pidx = 0; pold = 0; pcv = 0;
        for (int r = 0; r < 16; r++) begin
            if (lst[r]) begin
                a = st + 32'(k) * 32'd4;
                cur = adopt ? eub[r] : enb[r];
                eacc_addr[k] = a;
                eacc_we[k]   = !l && !aerr;
                eacc_wd[k]   = (k == 0 && r == int'(bs) && bs != 4'd15) ? bv : cur;
                if (l) begin
                    if (!ab) begin
                        if (eon && a == eaddr) begin
                            ab = 1;
                            if (pv) begin
                                if (adopt) eub[pidx] = pold;
                                else       enb[pidx] = pold;
                            end
                        end else begin
                            pv = 1; pidx = 4'(r); pold = cur;
                            if (r == 15) pcv = mdata(a);
                            else if (adopt) eub[r] = mdata(a);
                            else enb[r] = mdata(a);
                        end
                    end
                end else if (eon && a == eaddr) begin
                    serr = 1;
                end
                k++;
            end
        end
        eexc = aerr || ab || serr;
        if (l && ab && bs != 4'd15) enb[bs] = wbe ? fin : bv;
        estat = 0;
        if (l && lst[15] && !eexc) begin
            enb[15] = pcv;
            estat   = s;
        end
        // Prime the model and launch.
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            nb[i] = init_n(i);
            ub[i] = init_u(i);
        end
        if (bs != 4'd15) nb[bs] = bv;
        acc_cnt = 0; stat_seen = 0; err_on = eon; err_addr = eaddr;
        reg_list = lst; base_sel = bs; base_val = bv; up_mode = u;
        pre_mode = p; wb_req = w; user_sel = s; is_load = l; start = 1;
        @(negedge clk);
        start = 0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        got_exc = exc;
        @(negedge clk);
        // R10 and R11: completion latency.
        check(cyc == ((n == 0) ? 1 : n + 2), (n == 0) ? "R10" : "R11",
              "latency", 32'(cyc), 32'((n == 0) ? 1 : n + 2));
        // R1 and R2: access count and address sequence.
        ok = (acc_cnt == n);
        for (int i = 0; i < n && i < 16; i++) if (acc_addr[i] != eacc_addr[i]) ok = 0;
        check(ok, "R1", "access addresses", 32'(acc_cnt), 32'(n));
        // R4 and R7: write flags and store data.
        ok = 1;
        for (int i = 0; i < n && i < 16 && i < acc_cnt; i++) begin
            if (acc_we[i] != eacc_we[i]) ok = 0;
            if (eacc_we[i] && acc_wd[i] != eacc_wd[i]) ok = 0;
        end
        check(ok, "R4", "store data/flags", (n > 0) ? acc_wd[0] : 32'd0,
              (n > 0) ? eacc_wd[0] : 32'd0);
        // R3, R5, R8: both register banks.
        ok = 1;
        for (int i = 0; i < 16; i++) if (nb[i] != enb[i] || ub[i] != eub[i]) ok = 0;
        check(ok, "R5", "register file", nb[bs], enb[bs]);
        // R6 and R7: exception flag.
        check(got_exc == eexc, "R6", "exc", 32'(got_exc), 32'(eexc));
        // R9: status load pulse.
        check(stat_seen == estat, "R9", "status_we", 32'(stat_seen), 32'(estat));
    endtask

    initial begin
        logic [15:0] lists [8];
        logic [3:0]  bases [3];
        lists[0] = 16'h0000; lists[1] = 16'h0004; lists[2] = 16'h0080;
        lists[3] = 16'h8000; lists[4] = 16'h00F0; lists[5] = 16'hFFFF;
        lists[6] = 16'h8421; lists[7] = 16'h0086;
        bases[0] = 4'd2; bases[1] = 4'd7; bases[2] = 4'd15;
        rst_n = 0; start = 0; reg_list = '0; base_sel = '0; base_val = '0;
        up_mode = 0; pre_mode = 0; wb_req = 0; user_sel = 0; is_load = 0;
        err_on = 0; err_addr = '0; acc_cnt = 0; stat_seen = 0;
        repeat (3) @(negedge clk);
        // R12: reset state.
        check(!done && !exc && !mem_req && !rf_we && !status_we, "R12",
              "reset outputs", {27'd0, done, exc, mem_req, rf_we, status_we}, 32'd0);
        rst_n = 1;
        // R1, R2, R3, R4, R10: mode sweep.
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                for (int w = 0; w < 2; w++)
                    for (int li = 0; li < 8; li++)
                        for (int bi = 0; bi < 3; bi++)
                            run_case(lists[li], bases[bi], 32'h0000_0400,
                                     m[0], m[1], w[0], 1'b0, l[0], 1'b0, 32'd0);
        // R8 and R9: user bank and status load.
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++) begin
                run_case(16'h80F0, 4'd12, 32'h0000_0800, m[0], m[1], 1'b1, 1'b1, l[0], 1'b0, 32'd0);
                run_case(16'h00F0, 4'd12, 32'h0000_0800, m[0], m[1], 1'b1, 1'b1, l[0], 1'b0, 32'd0);
                run_case(16'h8000, 4'd12, 32'h0000_0800, m[0], m[1], 1'b0, 1'b1, l[0], 1'b0, 32'd0);
            end
        // R5 and R6: fault injected at each position.
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                for (int w = 0; w < 2; w++)
                    for (int bi = 0; bi < 2; bi++)
                        for (int pos = 0; pos < 8; pos++) begin
                            logic [31:0] sa;
                            sa = (m[0] ? 32'h0000_0600 : 32'h0000_0600 - 32'd32)
                                 + ((m[0] == m[1]) ? 32'd4 : 32'd0);
                            run_case(16'h8F07 & ~(bi[0] ? 16'h0000 : 16'h0000),
                                     bi[0] ? 4'd1 : 4'd5, 32'h0000_0600,
                                     m[0], m[1], w[0], 1'b0, l[0], 1'b1,
                                     sa + 32'(pos) * 32'd4);
                        end
        // R7: range limit, just inside and exactly at the boundary.
        for (int l = 0; l < 2; l++) begin
            run_case(16'h0003, 4'd9, 32'h0400_0000, 1'b1, 1'b0, 1'b1, 1'b0, l[0], 1'b0, 32'd0);
            run_case(16'h0001, 4'd9, 32'h0400_0000, 1'b0, 1'b1, 1'b1, 1'b0, l[0], 1'b0, 32'd0);
            run_case(16'h8001, 4'd9, 32'h03FF_FFFC, 1'b1, 1'b1, 1'b0, 1'b0, l[0], 1'b0, 32'd0);
            run_case(16'h8001, 4'd9, 32'h03FF_FFF8, 1'b1, 1'b1, 1'b0, 1'b0, l[0], 1'b0, 32'd0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule